// File: doc/BRIEF.md
# Receive Buffer with Hysteresis Flow Control

This block is the receive-side byte store of a serial port, sized by default for 128 bytes. It accepts one byte per cycle from the deserialiser and hands bytes to the host in arrival order. It also drives the ready-to-send line that paces the far-end sender.

In hysteresis mode two programmable levels steer that line. Once the stored count climbs past the upper level, the line drops. It comes back only after the count has fallen beneath the lower level. While the count sits between the two levels, the line keeps its last value. A nonzero lower level lets the sender restart while bytes are still waiting, so the host never finds the store empty just because the sender was held off.

A separate third level raises the host receive interrupt. Interrupt timing is therefore set on its own, apart from flow control. A legacy single-level mode uses that third level for both purposes: reaching it raises the interrupt and drops the line, and the line returns only when the store is completely empty.

Top module: `rx_hyst_fifo`

## Requirements
- R1: After a synchronous reset, `fill_count` is 0, `rts` is 1 and `rx_irq` is 0.
- R2: Bytes leave in the order they arrived. A pop accepted in cycle N gives `pop_valid`=1 in cycle N+1, with the byte in `pop_data`.
- R3: A push while the count equals DEPTH is dropped. A pop while the count is 0 is ignored and gives `pop_valid`=0. The count never exceeds DEPTH.
- R4: In hysteresis mode (`legacy_mode`=0), `rts` goes to 0 on the cycle after `fill_count` is strictly greater than `hi_lvl`.
- R5: In hysteresis mode, `rts` goes to 1 on the cycle after `fill_count` is strictly less than the effective low level.
- R6: In hysteresis mode, while the count lies between the effective low level and `hi_lvl` inclusive, `rts` keeps its previous value.
- R7: When `lo_lvl` >= `hi_lvl`, the effective low level is `hi_lvl`-1, or 0 when `hi_lvl` is 0. Otherwise it is `lo_lvl`.
- R8: In both modes, `rx_irq` is 1 on the cycle after `fill_count` >= `irq_lvl` and 0 otherwise. It does not depend on `hi_lvl` or `lo_lvl`.
- R9: In legacy mode (`legacy_mode`=1), `rts` goes to 0 on the cycle after `fill_count` >= `irq_lvl`.
- R10: In legacy mode, `rts` returns to 1 only on the cycle after `fill_count` is 0. At any other count below `irq_lvl` it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Receiver offers a byte |
| push_data | input | DW | Received byte |
| pop_req | input | 1 | Host takes one byte |
| legacy_mode | input | 1 | 1 selects single-level mode |
| hi_lvl | input | CW | Upper flow-control level |
| lo_lvl | input | CW | Lower flow-control level |
| irq_lvl | input | CW | Interrupt level (also the trigger in legacy mode) |
| pop_valid | output | 1 | `pop_data` holds a byte popped last cycle |
| pop_data | output | DW | Popped byte |
| fill_count | output | CW | Bytes currently stored |
| rts | output | 1 | Ready-to-send, 1 lets the sender transmit |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The properties relate `rts` and `rx_irq` to the count and the levels sampled one cycle earlier. They therefore assume that the level inputs and `legacy_mode` are quasi-static register values, not signals that toggle every cycle. The hold properties also assume the levels are not changed while the count sits inside the hold band. The stimulus reprograms the levels and the mode only while the store is empty, so `rts` enters each phase at 1 with nothing pending. All byte reads go through `pop_req`.

// File: rtl/rx_hyst_pkg.sv
package rx_hyst_pkg;
  typedef enum logic [1:0] {
    FC_HOLD = 2'd0,
    FC_STOP = 2'd1,
    FC_GO   = 2'd2
  } fc_act_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic push_ok, pop_ok;

  assign push_ok = push_valid && (count != FULL);
  assign pop_ok  = pop_req && (count != '0);

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  // storage array without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
    if (pop_ok)  pop_data    <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      pop_valid <= 1'b0;
    end else begin
      pop_valid <= pop_ok;
      if (push_ok) wr_ptr <= wr_nxt;
      if (pop_ok)  rd_ptr <= rd_nxt;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= FULL);
  a_r3_full_drop: assert property (@(posedge clk) disable iff (rst)
    (count == FULL && !pop_req) |=> count == FULL);
  a_r3_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !push_valid) |=> (count == '0 && !pop_valid));
  a_r2_pop_valid: assert property (@(posedge clk) disable iff (rst)
    (pop_req && count != '0) |=> pop_valid);
endmodule

// File: rtl/rxq_flow.sv
module rxq_flow
  import rx_hyst_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          legacy_mode,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] hi_lvl,
  input  logic [CW-1:0] lo_lvl,
  input  logic [CW-1:0] irq_lvl,
  output logic          rts,
  output logic          rx_irq
);
  logic [CW-1:0] lo_eff;
  fc_act_e act;

  always_comb begin
    if (lo_lvl >= hi_lvl) lo_eff = (hi_lvl == '0) ? '0 : hi_lvl - 1'b1;
    else                  lo_eff = lo_lvl;
  end

  always_comb begin
    act = FC_HOLD;
    if (legacy_mode) begin
      if (count >= irq_lvl)   act = FC_STOP;
      else if (count == '0)   act = FC_GO;
    end else begin
      if (count > hi_lvl)     act = FC_STOP;
      else if (count < lo_eff) act = FC_GO;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rts    <= 1'b1;
      rx_irq <= 1'b0;
    end else begin
      rx_irq <= (count >= irq_lvl);
      case (act)
        FC_STOP: rts <= 1'b0;
        FC_GO:   rts <= 1'b1;
        default: rts <= rts;
      endcase
    end
  end

  a_r4_rts_off: assert property (@(posedge clk) disable iff (rst)
    (!legacy_mode && count > hi_lvl) |=> !rts);
  a_r5_rts_on: assert property (@(posedge clk) disable iff (rst)
    (!legacy_mode && lo_lvl < hi_lvl && count < lo_lvl) |=> rts);
  a_r6_rts_hold: assert property (@(posedge clk) disable iff (rst)
    (!legacy_mode && lo_lvl < hi_lvl && count >= lo_lvl && count <= hi_lvl)
      |=> rts == $past(rts));
  a_r8_irq_set: assert property (@(posedge clk) disable iff (rst)
    (count >= irq_lvl) |=> rx_irq);
  a_r8_irq_clr: assert property (@(posedge clk) disable iff (rst)
    (count < irq_lvl) |=> !rx_irq);
  a_r9_legacy_off: assert property (@(posedge clk) disable iff (rst)
    (legacy_mode && count >= irq_lvl) |=> !rts);
  a_r10_legacy_hold: assert property (@(posedge clk) disable iff (rst)
    (legacy_mode && count != '0 && count < irq_lvl) |=> rts == $past(rts));
endmodule

// File: rtl/rx_hyst_fifo.sv
module rx_hyst_fifo #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  input  logic          legacy_mode,
  input  logic [CW-1:0] hi_lvl,
  input  logic [CW-1:0] lo_lvl,
  input  logic [CW-1:0] irq_lvl,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] fill_count,
  output logic          rts,
  output logic          rx_irq
);
  rxq_store #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_store (
    .clk        (clk),
    .rst        (rst),
    .push_valid (push_valid),
    .push_data  (push_data),
    .pop_req    (pop_req),
    .pop_valid  (pop_valid),
    .pop_data   (pop_data),
    .count      (fill_count)
  );

  rxq_flow #(.CW(CW)) u_flow (
    .clk         (clk),
    .rst         (rst),
    .legacy_mode (legacy_mode),
    .count       (fill_count),
    .hi_lvl      (hi_lvl),
    .lo_lvl      (lo_lvl),
    .irq_lvl     (irq_lvl),
    .rts         (rts),
    .rx_irq      (rx_irq)
  );
endmodule

// File: tb/test_rx_hyst_fifo.sv
module test_rx_hyst_fifo;
  localparam int DEPTH = 128;
  localparam int DW    = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_valid = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic pop_req = 1'b0;
  logic legacy_mode = 1'b0;
  logic [CW-1:0] hi_lvl = CW'(120);
  logic [CW-1:0] lo_lvl = CW'(16);
  logic [CW-1:0] irq_lvl = CW'(100);
  logic pop_valid;
  logic [DW-1:0] pop_data;
  logic [CW-1:0] fill_count;
  logic rts, rx_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rx_hyst_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) i_rx_hyst_fifo (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .pop_req(pop_req), .legacy_mode(legacy_mode), .hi_lvl(hi_lvl),
    .lo_lvl(lo_lvl), .irq_lvl(irq_lvl), .pop_valid(pop_valid),
    .pop_data(pop_data), .fill_count(fill_count), .rts(rts), .rx_irq(rx_irq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic push_n(int n, int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      push_valid = 1'b1;
      push_data  = DW'(base + i);
    end
    @(negedge clk);
    push_valid = 1'b0;
    settle();
  endtask

  task automatic pop_n(int n, bit verify, int base, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pop_req = 1'b1;
      @(negedge clk);
      pop_req = 1'b0;
      if (verify) begin
        chk({req, " pop_valid"}, int'(pop_valid), 1);
        chk({req, " order"}, int'(pop_data), (base + i) % 256);
      end
    end
    settle();
  endtask

  task automatic t_reset();
    chk("R1 count", int'(fill_count), 0);
    chk("R1 rts", int'(rts), 1);
    chk("R1 irq", int'(rx_irq), 0);
  endtask

  task automatic t_order();
    push_n(5, 8'hA0);
    chk("R3 count after push", int'(fill_count), 5);
    pop_n(5, 1'b1, 8'hA0, "R2");
    chk("R3 count drained", int'(fill_count), 0);
  endtask

  task automatic t_hyst();
    push_n(99, 0);
    chk("R8 irq below level", int'(rx_irq), 0);
    push_n(1, 0);
    chk("R8 irq at level", int'(rx_irq), 1);
    chk("R8 rts unaffected by irq", int'(rts), 1);
    push_n(20, 0);
    chk("R6 rts at hi", int'(rts), 1);
    push_n(1, 0);
    chk("R4 rts above hi", int'(rts), 0);
    pop_n(121 - 16, 1'b0, 0, "");
    chk("R6 rts held at lo", int'(rts), 0);
    chk("R8 irq cleared", int'(rx_irq), 0);
    pop_n(1, 1'b0, 0, "");
    chk("R5 rts below lo", int'(rts), 1);
    pop_n(15, 1'b0, 0, "");
    chk("R5 count empty", int'(fill_count), 0);
  endtask

  task automatic t_full();
    push_n(DEPTH + 2, 0);
    chk("R3 count saturates", int'(fill_count), DEPTH);
    chk("R4 rts when full", int'(rts), 0);
    pop_n(DEPTH, 1'b1, 0, "R3");
    @(negedge clk);
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
    chk("R3 empty pop valid", int'(pop_valid), 0);
    chk("R3 empty pop count", int'(fill_count), 0);
    chk("R5 rts after drain", int'(rts), 1);
  endtask

  task automatic t_clamp();
    hi_lvl = CW'(10);
    lo_lvl = CW'(50);
    settle();
    push_n(11, 0);
    chk("R7 rts off", int'(rts), 0);
    pop_n(2, 1'b0, 0, "");
    chk("R7 hold at 9", int'(rts), 0);
    pop_n(1, 1'b0, 0, "");
    chk("R7 on at 8", int'(rts), 1);
    pop_n(8, 1'b0, 0, "");
  endtask

  task automatic t_legacy();
    hi_lvl = CW'(120);
    lo_lvl = CW'(16);
    irq_lvl = CW'(8);
    legacy_mode = 1'b1;
    settle();
    push_n(7, 0);
    chk("R9 rts below trigger", int'(rts), 1);
    chk("R8 irq below trigger", int'(rx_irq), 0);
    push_n(1, 0);
    chk("R9 rts at trigger", int'(rts), 0);
    chk("R8 irq at trigger", int'(rx_irq), 1);
    pop_n(7, 1'b0, 0, "");
    chk("R10 rts held at 1", int'(rts), 0);
    chk("R8 irq cleared legacy", int'(rx_irq), 0);
    pop_n(1, 1'b0, 0, "");
    chk("R10 rts on empty", int'(rts), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_order();
    t_hyst();
    t_full();
    t_clamp();
    t_legacy();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule